// File: doc/BRIEF.md
# Fast-page DRAM module controller

This block is a synchronous controller for a 36-bit dynamic memory module built from four 9-bit byte lanes, each lane with its own column strobe. A client presents a word request (20-bit word address, 36-bit write data, 4-bit byte enables, read or write) through a valid/ready handshake. The controller splits the address into a 10-bit row and a 10-bit column, drives them one after the other on the shared address bus, and sequences the row strobes, the per-lane column strobes and the write enable so that every minimum and maximum time of the memory holds at the chosen clock period.

The module has two row strobes: one for the data devices of the lower lanes and one for the parity devices and the upper lanes. Both are pulsed together on every access. Writes always use early-write timing because data in and data out share the same pins. A refresh timer raises a request about every 15.6 µs, so that 1024 rows are refreshed within 16 ms. Each request is served by a column-before-row refresh cycle at the next idle point, ahead of any waiting access, and none is ever dropped. Each access opens a row, does one column access and closes the row again.

All timing limits are parameters in clock cycles, rounded up from the nanosecond limits of the fastest speed grade at a 10 ns clock.

Top module: `dram_fpm_ctrl`

## Requirements
- R1: After reset, both row strobes, all four column strobes and the write enable are high (inactive), the data output enable is low, rd_valid is low and req_ready is high.
- R2: When the row strobes fall for an access, dram_addr carries req_addr[19:10] (row). When the column strobes fall, it carries req_addr[9:0] (column).
- R3: dram_ras_data_n and dram_ras_par_n are equal in every cycle, so the parity devices see every access and every refresh.
- R4: On a write, exactly the lanes whose req_be bit is set see their column strobe fall. Lane i is data bits [9i+8:9i]. dram_we_n is already low when the strobes fall and stays low until they rise. dram_dq_oe is high with the write data during the whole access.
- R5: On a read, all four column strobes fall and dram_we_n stays high. rd_valid pulses for one cycle, and rd_data equals the value that dram_dq_in held in the last cycle in which the column strobes were low.
- R6: Within an access, the column strobes fall at least T_RCD=2 cycles after the row strobes. The row strobes stay low at least T_RAS=6 cycles and stay high at least T_RP=4 cycles between low periods. Successive row-strobe falls are at least T_RC=11 cycles apart.
- R7: Read data is sampled no earlier than T_RAC=6 cycles after the row strobes fall, and no earlier than T_CAC=2 cycles after the column strobes fall.
- R8: A refresh drives all four column strobes low at least T_CSR=1 cycle before the row strobes fall, and keeps them low for at least T_CHR=2 cycles after that fall. dram_we_n stays high throughout, and no data is driven.
- R9: A refresh starts once every REF_INTERVAL=1560 cycles. Under any traffic, consecutive refreshes start within 26 cycles of that spacing, and none is skipped.
- R10: req_ready is high only while the controller is idle with no refresh pending. Each cycle with req_valid and req_ready high starts exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in the upper half |
| req_wdata | input | 36 | Write data, four 9-bit lanes |
| req_be | input | 4 | Lane enables for writes |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 36 | Captured read data |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_data_n | output | 1 | Row strobe, lower-lane data devices |
| dram_ras_par_n | output | 1 | Row strobe, parity and upper-lane devices |
| dram_cas_n | output | 4 | Per-lane column strobes |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 36 | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 36 | Data from the memory |

## Verification
The assertions check on every cycle that the two row strobes move together, that a write's column strobes never fall before the write enable, that a refresh row-strobe fall sees the write enable high, that ready is only offered while all strobes are idle, that each row-strobe low period meets its minimum, and that the refresh backlog never overflows. Only the bench scenarios can show that data lands in the right lanes and reads back correctly, that the row and column halves appear in the right order, that data is not sampled before the memory drives it, and that refreshes keep their spacing under both idle and continuous traffic.

// File: rtl/dram_pkg.sv
package dram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PRE,
        ST_RCAS,
        ST_RRAS
    } dram_st_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int INTERVAL = 1560,
    parameter int PEND_W   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic pend_o
);
    localparam int TW = $clog2(INTERVAL + 1);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    typedef struct packed {
        logic [TW-1:0]     tmr;
        logic [PEND_W-1:0] pend;
    } tmr_t;

    tmr_t s_d, s_q;
    logic tick;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.tmr == TW'(INTERVAL - 1));
        s_d.tmr = tick ? '0 : s_q.tmr + 1'b1;
        if (tick && !ack_i)
            s_d.pend = s_q.pend + 1'b1;
        else if (!tick && ack_i)
            s_d.pend = s_q.pend - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = (s_q.pend != '0);

    assert_pend_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ack_i) |-> (s_q.pend != PEND_MAX));

    assert_ack_only_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> pend_o);

endmodule

// File: rtl/dram_cas_lanes.sv
module dram_cas_lanes #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_d,
    input  logic [LANES-1:0] mask_d,
    output logic [LANES-1:0] cas_n_o
);
    logic [LANES-1:0] cas_n_d, cas_n_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb cas_n_d[g] = !(act_d && mask_d[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cas_n_q[g] <= 1'b1;
            else        cas_n_q[g] <= cas_n_d[g];
        end
    end

    assign cas_n_o = cas_n_q;

endmodule

// File: rtl/dram_fpm_ctrl.sv
module dram_fpm_ctrl
    import dram_pkg::*;
#(
    parameter int MUX_W        = 10,
    parameter int LANES        = 4,
    parameter int LANE_W       = 9,
    parameter int T_RCD        = 2,
    parameter int T_CAC        = 2,
    parameter int T_RAC        = 6,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 4,
    parameter int T_RC         = 11,
    parameter int T_CSR        = 1,
    parameter int T_CHR        = 2,
    parameter int REF_INTERVAL = 1560
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [2*MUX_W-1:0]        req_addr,
    input  logic [LANES*LANE_W-1:0]   req_wdata,
    input  logic [LANES-1:0]          req_be,
    output logic                      rd_valid,
    output logic [LANES*LANE_W-1:0]   rd_data,
    output logic [MUX_W-1:0]          dram_addr,
    output logic                      dram_ras_data_n,
    output logic                      dram_ras_par_n,
    output logic [LANES-1:0]          dram_cas_n,
    output logic                      dram_we_n,
    output logic [LANES*LANE_W-1:0]   dram_dq_out,
    output logic                      dram_dq_oe,
    input  logic [LANES*LANE_W-1:0]   dram_dq_in
);
    localparam int DATA_W   = LANES * LANE_W;
    // column phase long enough for CAS width, RAS access time and RAS width
    localparam int CAS_HOLD = imax(imax(T_CAC, T_RAC - T_RCD), T_RAS - T_RCD);
    localparam int PRE_ACC  = imax(T_RP, T_RC - T_RCD - CAS_HOLD);
    localparam int REF_LOW  = imax(T_RAS, T_CHR);
    localparam int PRE_REF  = imax(T_RP, T_RC - T_CSR - REF_LOW);
    localparam int CNT_MAX  = imax(imax(T_RCD, CAS_HOLD), imax(imax(PRE_ACC, PRE_REF), imax(REF_LOW, T_CSR)));
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int LOW_W    = $clog2(T_RAS + 2);

    typedef struct packed {
        dram_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic              ras_d_n;
        logic              ras_p_n;
        logic              we_n;
        logic              oe;
        logic              cas_act;
        logic [LANES-1:0]  mask;
        logic [MUX_W-1:0]  addr;
        logic [MUX_W-1:0]  col;
        logic [DATA_W-1:0] dq;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } ctl_t;

    ctl_t s_d, s_q;
    logic ref_pend, ref_ack;

    dram_ref_timer #(
        .INTERVAL (REF_INTERVAL),
        .PEND_W   (3)
    ) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (ref_ack),
        .pend_o (ref_pend)
    );

    dram_cas_lanes #(
        .LANES (LANES)
    ) u_cas (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_d   (s_d.cas_act),
        .mask_d  (s_d.mask),
        .cas_n_o (dram_cas_n)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        ref_ack    = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_ack     = 1'b1;
                    s_d.st      = ST_RCAS;
                    s_d.cas_act = 1'b1;
                    s_d.mask    = '1;
                    s_d.we_n    = 1'b1;
                    s_d.cnt     = CNT_W'(T_CSR - 1);
                end else if (req_valid) begin
                    s_d.st      = ST_ROW;
                    s_d.ras_d_n = 1'b0;
                    s_d.ras_p_n = 1'b0;
                    s_d.addr    = req_addr[2*MUX_W-1:MUX_W];
                    s_d.col     = req_addr[MUX_W-1:0];
                    s_d.we_n    = !req_write;
                    s_d.oe      = req_write;
                    s_d.dq      = req_wdata;
                    s_d.mask    = req_write ? req_be : '1;
                    s_d.cnt     = CNT_W'(T_RCD - 1);
                end
            end
            ST_ROW: begin
                if (s_q.cnt == '0) begin
                    s_d.st      = ST_COL;
                    s_d.addr    = s_q.col;
                    s_d.cas_act = 1'b1;
                    s_d.cnt     = CNT_W'(CAS_HOLD - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (s_q.cnt == '0) begin
                    s_d.st      = ST_PRE;
                    s_d.ras_d_n = 1'b1;
                    s_d.ras_p_n = 1'b1;
                    s_d.cas_act = 1'b0;
                    s_d.we_n    = 1'b1;
                    s_d.oe      = 1'b0;
                    s_d.cnt     = CNT_W'(PRE_ACC - 1);
                    if (s_q.we_n) begin
                        s_d.rvalid = 1'b1;
                        s_d.rdata  = dram_dq_in;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RCAS: begin
                if (s_q.cnt == '0) begin
                    s_d.st      = ST_RRAS;
                    s_d.ras_d_n = 1'b0;
                    s_d.ras_p_n = 1'b0;
                    s_d.cnt     = CNT_W'(REF_LOW - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RRAS: begin
                if (s_q.cnt == '0) begin
                    s_d.st      = ST_PRE;
                    s_d.ras_d_n = 1'b1;
                    s_d.ras_p_n = 1'b1;
                    s_d.cas_act = 1'b0;
                    s_d.cnt     = CNT_W'(PRE_REF - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (s_q.cnt == '0) s_d.st = ST_IDLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.st      <= ST_IDLE;
            s_q.ras_d_n <= 1'b1;
            s_q.ras_p_n <= 1'b1;
            s_q.we_n    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready       = (s_q.st == ST_IDLE) && !ref_pend;
    assign rd_valid        = s_q.rvalid;
    assign rd_data         = s_q.rdata;
    assign dram_addr       = s_q.addr;
    assign dram_ras_data_n = s_q.ras_d_n;
    assign dram_ras_par_n  = s_q.ras_p_n;
    assign dram_we_n       = s_q.we_n;
    assign dram_dq_out     = s_q.dq;
    assign dram_dq_oe      = s_q.oe;

    // ---- checks ----
    logic [LOW_W-1:0] ras_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ras_low_q <= '0;
        else if (dram_ras_data_n)  ras_low_q <= '0;
        else if (ras_low_q != '1)  ras_low_q <= ras_low_q + 1'b1;
    end

    assert_ras_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dram_ras_data_n == dram_ras_par_n);

    assert_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&dram_cas_n) && $past(&dram_cas_n) && dram_dq_oe) |-> !dram_we_n);

    assert_ras_min_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_data_n) |-> (ras_low_q >= LOW_W'(T_RAS)));

    assert_cbr_we_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_data_n) && (dram_cas_n == '0) && $past(dram_cas_n == '0)) |-> (dram_we_n && !dram_dq_oe));

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_ras_data_n && (&dram_cas_n) && dram_we_n));

endmodule

// File: tb/tb_dram_fpm_ctrl.sv
module tb_dram_fpm_ctrl;
    localparam int T_RCD = 2, T_CAC = 2, T_RAC = 6, T_RAS = 6, T_RP = 4;
    localparam int T_RC = 11, T_CSR = 1, T_CHR = 2, INTERVAL = 1560;
    localparam logic [35:0] JUNK = 36'h9BAD0BAD5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [35:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready, rd_valid;
    logic [35:0] rd_data, dram_dq_out;
    logic [9:0]  dram_addr;
    logic        dram_ras_data_n, dram_ras_par_n, dram_we_n, dram_dq_oe;
    logic [3:0]  dram_cas_n;
    logic [35:0] dram_dq_in = JUNK;

    dram_fpm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_data_n(dram_ras_data_n), .dram_ras_par_n(dram_ras_par_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // golden and device contents
    logic [35:0] gold [logic [19:0]];
    logic [35:0] mem  [logic [19:0]];
    logic [19:0] cur_addr;
    logic        cur_write;
    logic [3:0]  cur_be;
    int accepted = 0;

    // behavioural memory device, sampled away from the clock edge
    bit   ras_prev = 1'b1, cas_any_prev = 1'b0;
    int   ras_age = 0, ras_hi_age = 100, cas_age = 0, cyc = 0;
    int   last_fall = -100, last_ref = -1, ref_count = 0, acc_count = 0, first_ref = -1;
    bit   in_ref = 1'b0, in_mon = 1'b0;
    logic [9:0] row_l, col_l;

    always @(negedge clk) begin
        bit ras_lo, cas_any, cas_all;
        cyc++;
        if (in_mon) begin
            ras_lo  = !dram_ras_data_n;
            cas_any = (dram_cas_n != 4'hF);
            cas_all = (dram_cas_n == 4'h0);
            chk(dram_ras_data_n == dram_ras_par_n, "R3 ras pair", dram_ras_par_n, dram_ras_data_n);
            if (req_ready)
                chk(!ras_lo && !cas_any, "R10 ready while idle", {ras_lo, cas_any}, 0);
            // RAS falling
            if (ras_lo && ras_prev) begin
                chk(ras_hi_age >= T_RP, "R6 precharge", ras_hi_age, T_RP);
                chk(cyc - last_fall >= T_RC, "R6 cycle time", cyc - last_fall, T_RC);
                last_fall = cyc;
                if (cas_all && cas_any_prev) begin
                    in_ref = 1'b1;
                    ref_count++;
                    chk(cas_age >= T_CSR, "R8 cas before ras", cas_age, T_CSR);
                    chk(dram_we_n && !dram_dq_oe, "R8 we high", {dram_we_n, dram_dq_oe}, 2'b10);
                    if (last_ref >= 0)
                        chk((cyc - last_ref <= INTERVAL + 26) && (cyc - last_ref >= INTERVAL - 26),
                            "R9 refresh spacing", cyc - last_ref, INTERVAL);
                    else first_ref = cyc;
                    last_ref = cyc;
                end else begin
                    in_ref = 1'b0;
                    acc_count++;
                    row_l = dram_addr;
                    chk(dram_addr == cur_addr[19:10], "R2 row", dram_addr, cur_addr[19:10]);
                end
            end
            // RAS rising
            if (!ras_lo && !ras_prev)
                chk(ras_age >= T_RAS, "R6 ras low width", ras_age, T_RAS);
            // CAS falling during an access
            if (cas_any && !cas_any_prev && ras_lo && !in_ref) begin
                col_l = dram_addr;
                chk(dram_addr == cur_addr[9:0], "R2 column", dram_addr, cur_addr[9:0]);
                chk(ras_age + 1 >= T_RCD, "R6 ras to cas", ras_age + 1, T_RCD);
                if (cur_write) begin
                    logic [35:0] w;
                    chk(!dram_we_n && dram_dq_oe, "R4 early write", {dram_we_n, dram_dq_oe}, 2'b01);
                    chk(dram_cas_n == ~cur_be, "R4 lane strobes", dram_cas_n, ~cur_be);
                    w = mem.exists({row_l, col_l}) ? mem[{row_l, col_l}] : '0;
                    for (int i = 0; i < 4; i++)
                        if (!dram_cas_n[i]) w[9*i +: 9] = dram_dq_out[9*i +: 9];
                    mem[{row_l, col_l}] = w;
                end else begin
                    chk(cas_all && dram_we_n, "R5 read strobes", {dram_cas_n, dram_we_n}, 5'b00001);
                end
            end
            // write enable held while a write's strobes are low
            if (cas_any && ras_lo && !in_ref && cur_write)
                chk(!dram_we_n, "R4 we held", dram_we_n, 0);
            // CAS rising in refresh
            if (!cas_any && cas_any_prev && in_ref)
                chk(ras_age >= T_CHR, "R8 cas hold", ras_age, T_CHR);
            // update ages
            ras_age    = ras_lo ? (ras_prev ? 1 : ras_age + 1) : 0;
            ras_hi_age = ras_lo ? 0 : (ras_prev ? ras_hi_age + 1 : 1);
            cas_age    = cas_any ? (cas_any_prev ? cas_age + 1 : 1) : 0;
            ras_prev     = !ras_lo;
            cas_any_prev = cas_any;
            // read data only valid once both access times are met
            if (ras_lo && cas_all && dram_we_n && !in_ref && ras_age >= T_RAC && cas_age >= T_CAC)
                dram_dq_in = mem.exists({row_l, col_l}) ? mem[{row_l, col_l}] : '0;
            else
                dram_dq_in = JUNK;
        end
    end

    task automatic issue(input bit wr, input logic [19:0] a, input logic [35:0] d, input logic [3:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        cur_addr = a; cur_write = wr; cur_be = be;
        accepted++;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [19:0] a, input logic [35:0] d, input logic [3:0] be);
        logic [35:0] g;
        issue(1'b1, a, d, be);
        g = gold.exists(a) ? gold[a] : '0;
        for (int i = 0; i < 4; i++)
            if (be[i]) g[9*i +: 9] = d[9*i +: 9];
        gold[a] = g;
    endtask

    task automatic do_read(input logic [19:0] a);
        logic [35:0] e;
        int n = 0;
        issue(1'b0, a, '0, 4'h0);
        while (!rd_valid && n < 40) begin @(negedge clk); n++; end
        e = gold.exists(a) ? gold[a] : '0;
        chk(rd_valid, "R5 read valid", rd_valid, 1);
        chk(rd_data == e, "R5 R7 read data", rd_data, e);
        @(negedge clk);
        chk(!rd_valid, "R5 single pulse", rd_valid, 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        summary();
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_1234;
        repeat (3) @(negedge clk);
        chk(dram_ras_data_n && dram_ras_par_n && dram_cas_n == 4'hF && dram_we_n && !dram_dq_oe,
            "R1 strobes in reset", {dram_ras_data_n, dram_ras_par_n, dram_cas_n, dram_we_n, dram_dq_oe}, 8'hFE);
        rst_n = 1'b1;
        cyc = 0;
        in_mon = 1'b1;
        @(negedge clk);
        chk(req_ready && !rd_valid && dram_ras_data_n && dram_cas_n == 4'hF,
            "R1 idle after reset", {req_ready, rd_valid}, 2'b10);

        // directed patterns
        do_write(20'h00000, 36'h123456789, 4'hF);
        do_write(20'hFFFFF, 36'hFEDCBA987, 4'hF);
        do_write(20'h12345, 36'hFFFFFFFFF, 4'hF);
        do_write(20'h12345, 36'h000000000, 4'b0101);
        do_write(20'h003FF, 36'h0AAAAAAAA, 4'b1000);
        do_write(20'hFFC00, 36'h555555555, 4'b0000);
        do_read(20'h00000);
        do_read(20'hFFFFF);
        do_read(20'h12345);
        do_read(20'h003FF);
        do_read(20'hFFC00);
        do_read(20'h54321);

        // mixed traffic across several refresh intervals
        for (int k = 0; k < 500; k++) begin
            logic [19:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = {lfsr[7:6], 8'h3C, lfsr[5:4], 8'hC3};
            if (lfsr[9]) do_write(a, {lfsr[31:0], lfsr[3:0]} ^ 36'h5A5A5A5A5, lfsr[13:10]);
            else         do_read(a);
        end

        // idle period: refresh keeps its spacing
        repeat (2 * INTERVAL + 100) @(negedge clk);

        chk(acc_count == accepted, "R10 one access per accept", acc_count, accepted);
        chk(first_ref >= INTERVAL - 2 && first_ref <= INTERVAL + 26, "R9 first refresh", first_ref, INTERVAL);
        chk(ref_count >= cyc / INTERVAL - 1 && ref_count <= cyc / INTERVAL, "R9 refresh count",
            ref_count, cyc / INTERVAL);
        summary();
    end
endmodule